// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Cell

This block is the boundary-scan slice for a single bidirectional I/O pad that also has a pull-up. Three pad-facing signals are the drive enable, the drive data and the observed input. They share a two-flop shift segment rather than taking one scan flop each. The pull-up enable is not a register of its own. It is computed from the port bit, the direction bit and a global pull-up disable, and a separate ordinary scan cell sits ahead of the pair in the chain to scan it.

A TAP controller and instruction decoder, both outside this block, supply four strobes on the test clock: capture, shift, update and test mode. With test mode low, the pad is driven from the functional port and direction registers whatever the chain is doing. With test mode high, shadow flops filled on update drive the pad drive enable, the pad data and the pull-up instead. The observed stage reads the raw pad input with no synchroniser, which lets an external tester see the real pin level.

Top module: `pin_bscan_cell`

## Requirements
- R1: While test_mode is 0, pad_oe equals dir_bit and pad_do equals port_bit at all times, whatever the capture, shift and update strobes are doing.
- R2: While test_mode is 0, pad_pu equals (NOT pull_disable) AND (NOT dir_bit) AND port_bit.
- R3: A clock edge with cap_en=1 loads the chain as follows. The pull-up cell takes the functional pull-up value from R2 and stage 0 takes dir_bit. Stage 1 takes pad_in as sampled at that same edge when the current pad_oe is 0, and the current pad_do when pad_oe is 1.
- R4: A clock edge with shift_en=1 and cap_en=0 moves the chain one place: scan_in goes to the pull-up cell, the pull-up cell goes to stage 0 and stage 0 goes to stage 1. scan_out is the stage 1 flop. A bit shifted in therefore appears at scan_out after the third shift edge.
- R5: When cap_en and shift_en are both 1 at an edge, the capture of R3 takes place and the shift does not.
- R6: A clock edge with upd_en=1 copies the pull-up cell, stage 0 and stage 1 into the pull-up, drive-enable and drive-data shadows. At every other edge the shadows hold, and shifting does not change them.
- R7: While test_mode is 1, pad_pu, pad_oe and pad_do equal the pull-up, drive-enable and drive-data shadows.
- R8: While rst_n is 0, every chain flop and every shadow is 0. So scan_out is 0, and with test_mode at 1 all three pad outputs are 0.
- R9: An edge with neither cap_en nor shift_en leaves all three chain flops unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| test_mode | input | 1 | 1 = shadows drive the pad, 0 = functional registers drive it |
| scan_in | input | 1 | Serial data into the pull-up cell |
| port_bit | input | 1 | Functional output data register bit |
| dir_bit | input | 1 | Functional direction bit, 1 = output |
| pull_disable | input | 1 | Global pull-up disable |
| pad_in | input | 1 | Raw level seen at the pad |
| scan_out | output | 1 | Serial data out of stage 1 |
| pad_oe | output | 1 | Pad drive enable |
| pad_do | output | 1 | Pad drive data |
| pad_pu | output | 1 | Pad pull-up enable |

## Verification
The bench sweeps every combination of port, direction, disable and pad level. It does this in functional mode and again with each shadow pattern loaded in test mode. After each capture it shifts the chain out and compares the bits with values computed from the stated expressions. The corner cases are these. A capture in test mode must choose between pad_in and the driven data by looking at the shadow drive enable and not the functional direction bit. A design that got this wrong would read its own data on an undriven pin. Shifting must leave the shadows alone, or the pad would glitch during a scan. Capture must win over shift when both strobes are high, or the chain would lose the sample. The pull-up term must invert both the direction bit and the disable, or a pin set as an output would still pull up.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // Pad-facing control triple: pull-up, drive enable, drive data.
  typedef struct packed {
    logic pu;
    logic oe;
    logic dout;
  } pad_ctl_t;

  localparam int PAD_CTL_W = $bits(pad_ctl_t);

  // Functional pull-up: only for an input pin whose port bit is set,
  // and only when pull-ups are not globally disabled.
  function automatic logic pullup_term(input logic pull_dis,
                                       input logic dir,
                                       input logic port);
    return (~pull_dis) & (~dir) & port;
  endfunction

  // Value observed by the shared stage: the driven data if the pad is
  // driven, otherwise the raw pad level.
  function automatic logic observe_term(input logic oe,
                                        input logic dout,
                                        input logic pin);
    return oe ? dout : pin;
  endfunction

endpackage

// File: rtl/bscan_std_cell.sv
module bscan_std_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic par_in,
  input  logic ser_in,
  output logic ser_q,
  output logic upd_q
);

  logic cap_act;
  logic shf_act;

  assign cap_act = cap_en;
  assign shf_act = shift_en & ~cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q <= RST_VAL;
    end else if (cap_act) begin
      ser_q <= par_in;
    end else if (shf_act) begin
      ser_q <= ser_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= RST_VAL;
    end else if (upd_en) begin
      upd_q <= ser_q;
    end
  end

endmodule

// File: rtl/bscan_pin_pair.sv
module bscan_pin_pair #(
  parameter logic OE_RST  = 1'b0,
  parameter logic DAT_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic ser_in,
  input  logic oe_cap,
  input  logic obs_cap,
  output logic st0_q,
  output logic st1_q,
  output logic sh_oe,
  output logic sh_dat
);

  localparam int STAGES = 2;

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] cap_vec;
  logic [STAGES-1:0] shf_vec;
  logic [STAGES-1:0] rst_vec;

  assign cap_vec = {obs_cap, oe_cap};
  assign shf_vec = {stg_q[0], ser_in};
  assign rst_vec = {DAT_RST, OE_RST};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[g] <= rst_vec[g];
      end else if (cap_en) begin
        stg_q[g] <= cap_vec[g];
      end else if (shift_en) begin
        stg_q[g] <= shf_vec[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_oe  <= OE_RST;
      sh_dat <= DAT_RST;
    end else if (upd_en) begin
      sh_oe  <= stg_q[0];
      sh_dat <= stg_q[1];
    end
  end

  assign st0_q = stg_q[0];
  assign st1_q = stg_q[1];

endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux
  import bscan_pkg::*;
(
  input  logic     test_mode,
  input  pad_ctl_t func_ctl,
  input  pad_ctl_t scan_ctl,
  output pad_ctl_t pad_ctl
);

  always_comb begin
    if (test_mode) begin
      pad_ctl = scan_ctl;
    end else begin
      pad_ctl = func_ctl;
    end
  end

endmodule

// File: rtl/pin_bscan_cell.sv
module pin_bscan_cell
  import bscan_pkg::*;
#(
  parameter logic [PAD_CTL_W-1:0] SHADOW_INIT = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic test_mode,
  input  logic scan_in,
  input  logic port_bit,
  input  logic dir_bit,
  input  logic pull_disable,
  input  logic pad_in,
  output logic scan_out,
  output logic pad_oe,
  output logic pad_do,
  output logic pad_pu
);

  localparam pad_ctl_t INIT_CTL = pad_ctl_t'(SHADOW_INIT);

  // Named internal events, visible to the bound checker.
  logic     func_pu;
  logic     obs_val;
  logic     pu_stage;
  logic     st0;
  logic     st1;
  logic     sh_pu;
  logic     sh_oe;
  logic     sh_dat;
  pad_ctl_t func_ctl;
  pad_ctl_t scan_ctl;
  pad_ctl_t pad_ctl;

  assign func_pu  = pullup_term(pull_disable, dir_bit, port_bit);
  assign func_ctl = '{pu: func_pu, oe: dir_bit, dout: port_bit};
  assign scan_ctl = '{pu: sh_pu, oe: sh_oe, dout: sh_dat};

  bscan_std_cell #(
    .RST_VAL (INIT_CTL.pu)
  ) u_pu_cell (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .upd_en   (upd_en),
    .par_in   (func_pu),
    .ser_in   (scan_in),
    .ser_q    (pu_stage),
    .upd_q    (sh_pu)
  );

  bscan_pin_pair #(
    .OE_RST  (INIT_CTL.oe),
    .DAT_RST (INIT_CTL.dout)
  ) u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .upd_en   (upd_en),
    .ser_in   (pu_stage),
    .oe_cap   (dir_bit),
    .obs_cap  (obs_val),
    .st0_q    (st0),
    .st1_q    (st1),
    .sh_oe    (sh_oe),
    .sh_dat   (sh_dat)
  );

  bscan_pad_mux u_mux (
    .test_mode (test_mode),
    .func_ctl  (func_ctl),
    .scan_ctl  (scan_ctl),
    .pad_ctl   (pad_ctl)
  );

  assign pad_pu   = pad_ctl.pu;
  assign pad_oe   = pad_ctl.oe;
  assign pad_do   = pad_ctl.dout;
  assign obs_val  = observe_term(pad_oe, pad_do, pad_in);
  assign scan_out = st1;

endmodule

// File: rtl/pin_bscan_cell_chk.sv
module pin_bscan_cell_chk (
  input logic clk,
  input logic rst_n,
  input logic cap_en,
  input logic shift_en,
  input logic upd_en,
  input logic test_mode,
  input logic scan_in,
  input logic port_bit,
  input logic dir_bit,
  input logic pull_disable,
  input logic pad_in,
  input logic scan_out,
  input logic pad_oe,
  input logic pad_do,
  input logic pad_pu,
  input logic pu_stage,
  input logic st0,
  input logic st1,
  input logic sh_pu,
  input logic sh_oe,
  input logic sh_dat
);

  p_func_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (pad_oe == dir_bit) && (pad_do == port_bit));

  p_func_pullup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> pad_pu == (!pull_disable && !dir_bit && port_bit));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (st0 == $past(dir_bit))
            && (pu_stage == $past(!pull_disable && !dir_bit && port_bit))
            && (st1 == $past(pad_oe ? pad_do : pad_in)));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (pu_stage == $past(scan_in))
                           && (st0 == $past(pu_stage))
                           && (st1 == $past(st0)));

  p_scan_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_out == st1);

  p_cap_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && shift_en) |=> (st0 == $past(dir_bit)));

  p_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (sh_pu == $past(pu_stage)) && (sh_oe == $past(st0))
            && (sh_dat == $past(st1)));

  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(sh_pu) && $stable(sh_oe) && $stable(sh_dat));

  p_test_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> (pad_pu == sh_pu) && (pad_oe == sh_oe) && (pad_do == sh_dat));

  p_reset_r8: assert property (@(posedge clk)
    !rst_n |-> !scan_out && !pu_stage && !st0 && !sh_pu && !sh_oe && !sh_dat);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !shift_en) |=> $stable(pu_stage) && $stable(st0) && $stable(st1));

endmodule

bind pin_bscan_cell pin_bscan_cell_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cap_en       (cap_en),
  .shift_en     (shift_en),
  .upd_en       (upd_en),
  .test_mode    (test_mode),
  .scan_in      (scan_in),
  .port_bit     (port_bit),
  .dir_bit      (dir_bit),
  .pull_disable (pull_disable),
  .pad_in       (pad_in),
  .scan_out     (scan_out),
  .pad_oe       (pad_oe),
  .pad_do       (pad_do),
  .pad_pu       (pad_pu),
  .pu_stage     (pu_stage),
  .st0          (st0),
  .st1          (st1),
  .sh_pu        (sh_pu),
  .sh_oe        (sh_oe),
  .sh_dat       (sh_dat)
);

// File: tb/pin_bscan_cell_bench.sv
module pin_bscan_cell_bench;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, test_mode = 1'b0;
  logic scan_in = 1'b0, port_bit = 1'b0, dir_bit = 1'b0;
  logic pull_disable = 1'b0, pad_in = 1'b0;
  logic scan_out, pad_oe, pad_do, pad_pu;

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pin_bscan_cell u_pin_bscan_cell (
    .clk (clk), .rst_n (rst_n), .cap_en (cap_en), .shift_en (shift_en),
    .upd_en (upd_en), .test_mode (test_mode), .scan_in (scan_in),
    .port_bit (port_bit), .dir_bit (dir_bit), .pull_disable (pull_disable),
    .pad_in (pad_in), .scan_out (scan_out), .pad_oe (pad_oe),
    .pad_do (pad_do), .pad_pu (pad_pu)
  );

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Drive strobes after a falling edge, take one rising edge, return at
  // the next falling edge with strobes cleared.
  task automatic pulse(input logic c, input logic s, input logic u, input logic si);
    cap_en = c; shift_en = s; upd_en = u; scan_in = si;
    @(posedge clk);
    @(negedge clk);
    cap_en = 1'b0; shift_en = 1'b0; upd_en = 1'b0;
  endtask

  // Fill chain so pull-up cell = a, stage 0 = b, stage 1 = c.
  task automatic load(input logic a, input logic b, input logic c);
    pulse(1'b0, 1'b1, 1'b0, c);
    pulse(1'b0, 1'b1, 1'b0, b);
    pulse(1'b0, 1'b1, 1'b0, a);
  endtask

  // Read out stage 1, stage 0, pull-up cell in that order.
  task automatic read3(output logic r1, output logic r0, output logic rpu);
    r1 = scan_out;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    r0 = scan_out;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    rpu = scan_out;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic r1, r0, rpu;
    #1 rst_n = 1'b0;
    @(negedge clk);
    // R8: reset state
    test_mode = 1'b1; port_bit = 1'b1; dir_bit = 1'b0; pull_disable = 1'b0;
    #1;
    chk("R8", "scan_out", scan_out, 1'b0);
    chk("R8", "pad_oe", pad_oe, 1'b0);
    chk("R8", "pad_do", pad_do, 1'b0);
    chk("R8", "pad_pu", pad_pu, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    test_mode = 1'b0;
    @(negedge clk);

    // R1, R2: functional pass-through under all inputs and strobe activity
    for (int v = 0; v < 8; v++) begin
      for (int k = 0; k < 8; k++) begin
        port_bit = v[0]; dir_bit = v[1]; pull_disable = v[2];
        cap_en = k[0]; shift_en = k[1]; upd_en = k[2]; scan_in = v[0] ^ k[0];
        pad_in = k[1];
        #1;
        chk("R1", "pad_oe", pad_oe, dir_bit);
        chk("R1", "pad_do", pad_do, port_bit);
        chk("R2", "pad_pu", pad_pu, !pull_disable && !dir_bit && port_bit);
        @(posedge clk);
        @(negedge clk);
        cap_en = 1'b0; shift_en = 1'b0; upd_en = 1'b0;
      end
    end

    // R4, R6, R7: shift patterns in, update, drive pad, shift out
    for (int p = 0; p < 8; p++) begin
      test_mode = 1'b0;
      load(p[2], p[1], p[0]);
      chk("R4", "scan_out after three shifts", scan_out, p[0]);
      pulse(1'b0, 1'b0, 1'b1, 1'b0);
      test_mode = 1'b1;
      port_bit = ~p[0]; dir_bit = ~p[1]; pull_disable = p[2];
      #1;
      chk("R7", "pad_pu", pad_pu, p[2]);
      chk("R7", "pad_oe", pad_oe, p[1]);
      chk("R7", "pad_do", pad_do, p[0]);
      read3(r1, r0, rpu);
      chk("R4", "stage1 out", r1, p[0]);
      chk("R4", "stage0 out", r0, p[1]);
      chk("R4", "pull-up cell out", rpu, p[2]);
      #1;
      chk("R6", "pad_pu after shifting", pad_pu, p[2]);
      chk("R6", "pad_oe after shifting", pad_oe, p[1]);
      chk("R6", "pad_do after shifting", pad_do, p[0]);
    end

    // R3: capture sweep in functional and test mode
    for (int tm = 0; tm < 2; tm++) begin
      for (int v = 0; v < 16; v++) begin
        logic shp, sho, shd, eoe, edo, eobs;
        shp = v[0]; sho = v[1] ^ v[3]; shd = ~v[2];
        test_mode = 1'b0;
        load(shp, sho, shd);
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        test_mode = tm[0];
        dir_bit = v[0]; port_bit = v[1]; pull_disable = v[2]; pad_in = v[3];
        eoe  = tm[0] ? sho : v[0];
        edo  = tm[0] ? shd : v[1];
        eobs = eoe ? edo : v[3];
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        read3(r1, r0, rpu);
        chk("R3", "stage1 capture", r1, eobs);
        chk("R3", "stage0 capture", r0, v[0]);
        chk("R3", "pull-up capture", rpu, !v[2] && !v[0] && v[1]);
      end
    end

    // R5: capture beats shift
    test_mode = 1'b0;
    load(1'b1, 1'b1, 1'b1);
    dir_bit = 1'b0; port_bit = 1'b0; pull_disable = 1'b1; pad_in = 1'b0;
    pulse(1'b1, 1'b1, 1'b0, 1'b1);
    read3(r1, r0, rpu);
    chk("R5", "stage1", r1, 1'b0);
    chk("R5", "stage0", r0, 1'b0);
    chk("R5", "pull-up cell", rpu, 1'b0);

    // R9: idle edges hold the chain
    load(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      pad_in = i[0]; dir_bit = ~i[0]; scan_in = i[0];
      @(negedge clk);
    end
    read3(r1, r0, rpu);
    chk("R9", "stage1 held", r1, 1'b1);
    chk("R9", "stage0 held", r0, 1'b0);
    chk("R9", "pull-up cell held", rpu, 1'b1);

    report();
  end

endmodule